// File: doc/BRIEF.md
# External Data Access Router

This block sits between a processor core and its data-memory space. It steers every move-external style access either to an on-chip auxiliary RAM or to a multiplexed external bus. The core offers one access at a time on a valid/ready request channel. Each access carries a direction, an addressing form and an address. The addressing form is either an 8-bit register-indirect address or a 16-bit pointer. The block answers with a one-cycle completion strobe that also carries any read data.

The routing decision uses a mode input, the addressing form and the size of the auxiliary RAM. Internal accesses finish in a fixed short time and leave every external pin untouched. External accesses run a fixed sequence. An address-latch cycle comes first. It is followed by an active-low read or write strobe whose length is chosen by a stretch input, so that slow peripherals can be served.

Back-pressure rules: a request moves only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the completion strobe, and requests offered in that window are ignored. The response channel cannot be stalled. `rsp_valid` is high for exactly one cycle, and the core must take `rsp_rdata` in that cycle.

Top module: `xdata_router`

## Requirements
- R1: With `cfg_ext_only`=0, a pointer-form access whose address is below `RAM_BYTES` (1792 by default, so 0x0000..0x06FF) goes to the internal RAM. No external pin (`ext_lo_out`, `ext_lo_oe`, `ext_hi`, `ext_ale`, `ext_rd_n`, `ext_wr_n`) changes during it, and a read returns the byte last written there.
- R2: With `cfg_ext_only`=0, a pointer-form access at or above `RAM_BYTES` (for example 0x0700) runs on the external bus.
- R3: A register-indirect access (`req_ptr`=0) uses only `req_addr[7:0]`, zero-extended. The upper address bits are ignored, and with `cfg_ext_only`=0 such an access reaches internal location 0x00..0xFF.
- R4: With `cfg_ext_only`=1, every access goes to the external bus, whatever its form or address.
- R5: An external pointer-form access drives `req_addr[15:8]` on `ext_hi` and `req_addr[7:0]` on `ext_lo_out`, with `ext_lo_oe`=1 and `ext_ale` high for exactly one cycle.
- R6: An external register-indirect access leaves `ext_hi` at the value it held before, which gives external paging.
- R7: An external read pulls only `ext_rd_n` low and releases `ext_lo_oe` during the strobe. An external write pulls only `ext_wr_n` low and drives `req_wdata` on `ext_lo_out` with `ext_lo_oe`=1.
- R8: The strobe lasts `SHORT_CLKS` (6) cycles when `cfg_stretch`=0 at acceptance, and `LONG_CLKS` (30) cycles when it is 1.
- R9: External read data is sampled from `ext_lo_in` at the clock edge where the read strobe rises, and is returned on `rsp_rdata`.
- R10: `rsp_valid` is high for one cycle, 1 cycle after acceptance for an internal access and strobe length + 1 cycles after acceptance for an external one. `busy` falls in that same cycle.
- R11: While `busy`=1, `req_ready`=0 and any offered request is ignored. It causes no response, no RAM write and no bus activity.
- R12: After reset, `busy`=0, `req_ready`=1, `rsp_valid`=0, `ext_ale`=0, `ext_rd_n`=1, `ext_wr_n`=1 and `ext_lo_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_only | input | 1 | 1: route every access to the external bus |
| cfg_stretch | input | 1 | 1: long strobes (LONG_CLKS), 0: short strobes (SHORT_CLKS) |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1: write, 0: read |
| req_ptr | input | 1 | 1: 16-bit pointer form, 0: 8-bit register-indirect form |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid |
| ext_lo_out | output | 8 | Multiplexed low address / write data |
| ext_lo_oe | output | 1 | Output enable for ext_lo_out |
| ext_lo_in | input | 8 | Read data from the low port |
| ext_hi | output | ADDR_W-8 | High address byte |
| ext_ale | output | 1 | Address latch strobe |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
An internal access finishes one cycle after the accepting edge. An external one finishes strobe length plus one cycles after it: one address-latch cycle, then 6 or 30 strobe cycles. The address-latch pulse appears in the cycle right after acceptance. The bench records the cycle number of each accepting edge in the expected item it queues. The monitor samples on falling edges and compares the distance to the completion strobe against that figure. The same monitor counts latch cycles, strobe-low cycles and pin changes between completions, so width, address and no-toggle checks are tied to the same timeline.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LATCH  = 2'd1,
    SEQ_STROBE = 2'd2
  } xdr_seq_e;
endpackage

// File: rtl/xdr_route_dec.sv
module xdr_route_dec #(
  parameter int ADDR_W    = 16,
  parameter int RAM_BYTES = 1792,
  localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
  input  logic              ext_only,
  input  logic              ptr_form,
  input  logic [ADDR_W-1:0] addr,
  output logic              to_ext,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(RAM_BYTES);

  logic [ADDR_W-1:0] eff_addr;

  // Register-indirect form only carries eight address bits.
  always_comb begin
    if (ptr_form) eff_addr = addr;
    else          eff_addr = {{(ADDR_W-8){1'b0}}, addr[7:0]};
  end

  assign to_ext   = ext_only | ({1'b0, eff_addr} >= LIMIT);
  assign ram_addr = eff_addr[RAM_AW-1:0];
endmodule

// File: rtl/xdr_aux_ram.sv
module xdr_aux_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1792,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/xdr_ext_seq.sv
module xdr_ext_seq
  import xdr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SHORT_CLKS = 6,
  parameter int LONG_CLKS  = 30,
  localparam int CNT_W     = $clog2(LONG_CLKS + 1),
  localparam int HI_W      = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              write,
  input  logic              ptr_form,
  input  logic              stretch,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              fin,
  output logic [7:0]        lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  xdr_seq_e   state;
  logic [CNT_W-1:0] cnt;
  logic       wr_l;
  logic       long_l;
  logic [7:0] wd_l;

  assign fin = (state == SEQ_STROBE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      cnt    <= '0;
      wr_l   <= 1'b0;
      long_l <= 1'b0;
      wd_l   <= '0;
      lo_out <= '0;
      lo_oe  <= 1'b0;
      hi_out <= '0;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            state  <= SEQ_LATCH;
            ale    <= 1'b1;
            lo_out <= addr[7:0];
            lo_oe  <= 1'b1;
            if (ptr_form) hi_out <= addr[ADDR_W-1:8];
            wr_l   <= write;
            wd_l   <= wdata;
            long_l <= stretch;
          end
        end
        SEQ_LATCH: begin
          ale   <= 1'b0;
          state <= SEQ_STROBE;
          cnt   <= long_l ? CNT_W'(LONG_CLKS - 1) : CNT_W'(SHORT_CLKS - 1);
          if (wr_l) begin
            lo_out <= wd_l;
            wr_n   <= 1'b0;
          end else begin
            lo_oe <= 1'b0;
            rd_n  <= 1'b0;
          end
        end
        SEQ_STROBE: begin
          if (cnt == '0) begin
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
            lo_oe <= 1'b0;
            state <= SEQ_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Checker: width of each strobe pulse.
  logic             strobe_low;
  logic [CNT_W:0]   wc;
  assign strobe_low = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wc <= '0;
    else if (strobe_low) wc <= wc + 1'b1;
    else                 wc <= '0;
  end

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_low && $past(strobe_low)) |->
      (wc == (long_l ? (CNT_W+1)'(LONG_CLKS) : (CNT_W+1)'(SHORT_CLKS))));

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);

  assert_ptr_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ptr_form && state == SEQ_IDLE) |=>
      (ale && hi_out == $past(addr[ADDR_W-1:8])));

  assert_ale_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_paging_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ptr_form && state == SEQ_IDLE) |=> $stable(hi_out));
endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAM_BYTES  = 1792,
  parameter int SHORT_CLKS = 6,
  parameter int LONG_CLKS  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_only,
  input  logic              cfg_stretch,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ptr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [7:0]        ext_lo_out,
  output logic              ext_lo_oe,
  input  logic [7:0]        ext_lo_in,
  output logic [ADDR_W-9:0] ext_hi,
  output logic              ext_ale,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  logic              accept;
  logic              to_ext;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_en;
  logic              ext_start;
  logic              ext_fin;
  logic              int_pend;
  logic [DATA_W-1:0] ram_q;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;
  assign ram_en    = accept && !to_ext;
  assign ext_start = accept && to_ext;

  xdr_route_dec #(
    .ADDR_W    (ADDR_W),
    .RAM_BYTES (RAM_BYTES)
  ) u_route (
    .ext_only (cfg_ext_only),
    .ptr_form (req_ptr),
    .addr     (req_addr),
    .to_ext   (to_ext),
    .ram_addr (ram_addr)
  );

  xdr_aux_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (RAM_BYTES)
  ) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (req_write),
    .addr  (ram_addr),
    .wdata (req_wdata),
    .rdata (ram_q)
  );

  xdr_ext_seq #(
    .ADDR_W     (ADDR_W),
    .SHORT_CLKS (SHORT_CLKS),
    .LONG_CLKS  (LONG_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ext_start),
    .write    (req_write),
    .ptr_form (req_ptr),
    .stretch  (cfg_stretch),
    .addr     (req_addr),
    .wdata    (req_wdata[7:0]),
    .fin      (ext_fin),
    .lo_out   (ext_lo_out),
    .lo_oe    (ext_lo_oe),
    .hi_out   (ext_hi),
    .ale      (ext_ale),
    .rd_n     (ext_rd_n),
    .wr_n     (ext_wr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      int_pend  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      int_pend  <= ram_en;
      rsp_valid <= int_pend | ext_fin;
      if (accept)                   busy <= 1'b1;
      else if (int_pend || ext_fin) busy <= 1'b0;
      if (int_pend)     rsp_rdata <= ram_q;
      else if (ext_fin) rsp_rdata <= DATA_W'(ext_lo_in);
    end
  end

  assert_quiet_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend |-> $stable({ext_lo_out, ext_lo_oe, ext_hi, ext_ale, ext_rd_n, ext_wr_n}));

  assert_ext_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> ext_ale);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_with_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy));
endmodule

// File: tb/xdata_router_tb.sv
`timescale 1ns/1ps
module xdata_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ext_only = 1'b0, cfg_stretch = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ptr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, busy, rsp_valid;
  logic [7:0]  rsp_rdata, ext_lo_out, ext_lo_in, ext_hi;
  logic        ext_lo_oe, ext_ale, ext_rd_n, ext_wr_n;

  always #2.5 clk = ~clk;

  xdata_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_only(cfg_ext_only), .cfg_stretch(cfg_stretch),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_ptr(req_ptr),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ext_lo_out(ext_lo_out), .ext_lo_oe(ext_lo_oe),
    .ext_lo_in(ext_lo_in), .ext_hi(ext_hi), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n));

  typedef struct {
    string      req;
    bit         is_ext;
    bit         is_read;
    logic [7:0] data;
    int         dev_addr;
    int         width;
    int         acc;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, cyc = 0;

  function automatic logic [7:0] dev_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  logic [15:0] dev_addr = '0;
  assign ext_lo_in = ext_rd_n ? 8'h00 : dev_f(dev_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: observes the external bus and pops the scoreboard on completion.
  int tog = 0, ale_n = 0, rd_w = 0, wr_w = 0;
  logic [7:0]  wr_seen = '0;
  logic [20:0] prev_pins = '0;
  always @(negedge clk) begin
    logic [20:0] pv;
    pv = {ext_lo_out, ext_lo_oe, ext_hi, ext_ale, ext_rd_n, ext_wr_n, 1'b0};
    if (rst_n) begin
      if (pv != prev_pins) tog++;
      if (ext_ale) begin ale_n++; dev_addr = {ext_hi, ext_lo_out}; end
      if (!ext_rd_n) rd_w++;
      if (!ext_wr_n) begin wr_w++; wr_seen = ext_lo_out;
        if (!ext_lo_oe) chk(0, "R7", "write strobe without drive", 0, 1); end
      if (!ext_rd_n && ext_lo_oe) chk(0, "R7", "read strobe with drive", 1, 0);
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R11", "unexpected response", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(busy == 1'b0, "R10", "busy at done", busy, 0);
          chk(cyc - it.acc == (it.is_ext ? it.width + 1 : 1), "R10",
              {it.req, " latency"}, cyc - it.acc, it.is_ext ? it.width + 1 : 1);
          if (it.is_read)
            chk(rsp_rdata == it.data, it.is_ext ? "R9" : it.req, "read data",
                rsp_rdata, it.data);
          if (it.is_ext) begin
            chk(ale_n == 1, "R5", "latch pulses", ale_n, 1);
            chk(dev_addr == it.dev_addr[15:0], it.req, "bus address", dev_addr, it.dev_addr);
            chk((it.is_read ? rd_w : wr_w) == it.width, "R8", "strobe width",
                it.is_read ? rd_w : wr_w, it.width);
            chk((it.is_read ? wr_w : rd_w) == 0, "R7", "wrong strobe",
                it.is_read ? wr_w : rd_w, 0);
            if (!it.is_read) chk(wr_seen == it.data, "R7", "write data", wr_seen, it.data);
          end else begin
            chk(tog == 0 && ale_n == 0, "R1", {it.req, " pin activity"}, tog, 0);
          end
        end
        tog = 0; ale_n = 0; rd_w = 0; wr_w = 0;
      end
    end
    prev_pins = pv;
  end

  // Driver: issues one access and queues what it should produce.
  task automatic op(input string req, input bit wr, input bit ptr, input logic [15:0] a,
                    input logic [7:0] d, input bit mode, input bit str, input bit ext,
                    input int daddr, input logic [7:0] exp_d);
    item_t it;
    @(negedge clk);
    cfg_ext_only = mode; cfg_stretch = str;
    req_write = wr; req_ptr = ptr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    it.req = req; it.is_ext = ext; it.is_read = !wr; it.data = wr ? d : exp_d;
    it.dev_addr = daddr; it.width = str ? 30 : 6; it.acc = cyc;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && req_ready && !rsp_valid, "R12", "idle handshake", busy, 0);
    chk(!ext_ale && ext_rd_n && ext_wr_n && !ext_lo_oe, "R12", "idle pins",
        {ext_ale, ext_rd_n, ext_wr_n, ext_lo_oe}, 4'b0110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    op("R1", 1, 1, 16'h0010, 8'hA5, 0, 0, 0, 0, 8'h00);
    op("R1", 0, 1, 16'h0010, 8'h00, 0, 0, 0, 0, 8'hA5);
    op("R1", 1, 1, 16'h06FF, 8'h3C, 0, 0, 0, 0, 8'h00);
    op("R1", 0, 1, 16'h06FF, 8'h00, 0, 0, 0, 0, 8'h3C);
    op("R1", 1, 1, 16'h0020, 8'h11, 0, 0, 0, 0, 8'h00);
    op("R3", 1, 0, 16'hAB44, 8'hC7, 0, 0, 0, 0, 8'h00);
    op("R3", 0, 1, 16'h0044, 8'h00, 0, 0, 0, 0, 8'hC7);
    op("R3", 0, 0, 16'h3344, 8'h00, 0, 0, 0, 0, 8'hC7);
    op("R2", 0, 1, 16'h0700, 8'h00, 0, 0, 1, 16'h0700, dev_f(16'h0700));
    op("R5", 1, 1, 16'h1234, 8'h77, 0, 1, 1, 16'h1234, 8'h00);
    op("R6", 0, 0, 16'h0056, 8'h00, 1, 0, 1, 16'h1256, dev_f(16'h1256));
    op("R4", 0, 1, 16'h0010, 8'h00, 1, 1, 1, 16'h0010, dev_f(16'h0010));
    op("R4", 1, 0, 16'h0099, 8'h3E, 1, 0, 1, 16'h0099, 8'h00);

    // R11: a request offered while busy must be ignored.
    fork
      op("R2", 0, 1, 16'h8001, 8'h00, 0, 0, 1, 16'h8001, dev_f(16'h8001));
      begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
        cfg_ext_only = 1'b0; req_write = 1'b1; req_ptr = 1'b1;
        req_addr = 16'h0020; req_wdata = 8'hEE; req_valid = 1'b1;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    op("R11", 0, 1, 16'h0020, 8'h00, 0, 0, 0, 0, 8'h11);

    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !busy, "R10", "final idle", busy, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule